// File: doc/BRIEF.md
# Transmit Input Parity Checker

This block sits on the parallel character input of a serial transmitter. It checks that each character presented to it carries odd parity. A character has an 8-bit data byte, a 2-bit control field and one parity bit. A three-level mode selection sets which of these bits the check covers. The coverage also depends on whether the downstream 8b/10b encoder is in use or bypassed. A failed check raises a one-cycle error pulse on the clock after the character is sampled.

Checking is held off in two situations. The first is the whole time the transmit self-test runs, because the data and control inputs are then unused. The second is a fixed window of characters after a word synchronisation sequence is requested, because the transmitter generates those characters itself.

A small state machine tracks this. Its states are `ST_CHECK` (normal checking), `ST_HOLD` (inside the post-sync window) and `ST_SELFTEST` (self-test running). Its transitions are:
- CHECK→HOLD on an accepted sync request.
- HOLD→HOLD, with the window reloaded, on a repeated request.
- HOLD→CHECK when the last window character has been consumed.
- any→SELFTEST while self-test is high.
- SELFTEST→CHECK, or SELFTEST→HOLD on a sync request, once self-test drops.

Top module: `tx_parity_checker`

## Requirements
- R1: Parity is odd. A checked character whose covered bits, including the parity bit, hold an even number of ones is flagged. One with an odd count is not flagged.
- R2: `mode_code` 2'b00 (LOW) disables checking. The code 2'b01 is reserved and also disables checking.
- R3: Three settings cover `tx_data`, `tx_ctl` and `tx_par`: `mode_code` 2'b11 (HIGH) with the encoder either enabled or bypassed, and `mode_code` 2'b10 (MID) with `enc_bypass`=1.
- R4: With `mode_code` 2'b10 (MID) and `enc_bypass`=0, only `tx_data` and `tx_par` are covered. `tx_ctl` has no effect on the result.
- R5: A character presented with `sync_req`=1 while checking is active is itself checked. The next 15 characters with `char_valid`=1 are not checked. The 16th one is checked again.
- R6: A `sync_req` on a character inside the window is not checked and restarts the window. The 15 following characters are then unchecked.
- R7: While `selftest`=1, no character is checked and any running window is abandoned. The first character after `selftest` falls is checked.
- R8: `par_err` rises on the clock edge after the failing character is sampled and stays high for exactly one cycle per failing character. It is never raised for a cycle with `char_valid`=0.
- R9: Reset (`rst_n` low, asynchronous) clears `par_err` and the suppression window.
- R10: Cycles with `char_valid`=0 do not count toward the 15-character window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | A character is presented this cycle |
| tx_data | input | 8 | Data byte |
| tx_ctl | input | 2 | Control field |
| tx_par | input | 1 | Parity bit supplied with the character |
| mode_code | input | 2 | Coverage mode: 00 LOW, 10 MID, 11 HIGH, 01 reserved |
| enc_bypass | input | 1 | 1 when the downstream encoder is bypassed |
| selftest | input | 1 | Transmit self-test running |
| sync_req | input | 1 | Word sync sequence starts with this character |
| par_err | output | 1 | One-cycle pulse for a failed parity check |

## Verification
The window counter and the state register are invisible at the ports. A wrong value in either shows up only as a missing or spurious `par_err` pulse on a deliberately bad character. The bench therefore drives characters with even parity at the boundaries: the character that carries the sync request, the 15th and 16th characters after it, the first character after self-test ends, and the first character after reset. A miscount then shows on the very next edge. A wrong coverage decode shows within one cycle when `tx_ctl` alone is flipped under each mode and bypass combination.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RSV  = 2'b01,
        MODE_MID  = 2'b10,
        MODE_HIGH = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        COV_NONE = 2'd0,
        COV_DATA = 2'd1,
        COV_FULL = 2'd2
    } cover_e;

    typedef enum logic [1:0] {
        ST_CHECK    = 2'd0,
        ST_HOLD     = 2'd1,
        ST_SELFTEST = 2'd2
    } win_state_e;

endpackage

// File: rtl/tpc_cover_sel.sv
module tpc_cover_sel
    import tpc_pkg::*;
(
    input  logic [1:0] mode_code,
    input  logic       enc_bypass,
    output cover_e     cov
);

    mode_e mode;

    always_comb begin
        mode = mode_e'(mode_code);
        unique case (mode)
            MODE_HIGH: cov = COV_FULL;
            MODE_MID:  cov = enc_bypass ? COV_FULL : COV_DATA;
            MODE_OFF,
            MODE_RSV:  cov = COV_NONE;
            default:   cov = COV_NONE;
        endcase
    end

endmodule

// File: rtl/tpc_parity_tree.sv
module tpc_parity_tree #(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CTL_W-1:0]  ctl,
    input  logic              par,
    output logic              odd_data,
    output logic              odd_full
);

    // running XOR across the data byte, seeded with the parity bit
    logic [DATA_W:0] d_chain;
    logic [CTL_W:0]  c_chain;

    assign d_chain[0] = par;
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_dbit
            assign d_chain[gi+1] = d_chain[gi] ^ data[gi];
        end
    endgenerate

    assign c_chain[0] = d_chain[DATA_W];
    generate
        for (gi = 0; gi < CTL_W; gi++) begin : g_cbit
            assign c_chain[gi+1] = c_chain[gi] ^ ctl[gi];
        end
    endgenerate

    assign odd_data = d_chain[DATA_W];
    assign odd_full = c_chain[CTL_W];

endmodule

// File: rtl/tpc_window_ctrl.sv
module tpc_window_ctrl
    import tpc_pkg::*;
#(
    parameter int WINDOW_LEN = 15,
    localparam int CNT_W = $clog2(WINDOW_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_valid,
    input  logic sync_req,
    input  logic selftest,
    output logic check_en
);

    localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(WINDOW_LEN);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(1);

    win_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CHECK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (selftest) begin
            st_d  = ST_SELFTEST;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_CHECK, ST_SELFTEST: begin
                    st_d = ST_CHECK;
                    if (char_valid && sync_req) begin
                        st_d  = ST_HOLD;
                        cnt_d = LOAD_C;
                    end
                end
                ST_HOLD: begin
                    if (char_valid) begin
                        if (sync_req) begin
                            cnt_d = LOAD_C;
                        end else if (cnt_q == LAST_C) begin
                            cnt_d = '0;
                            st_d  = ST_CHECK;
                        end else begin
                            cnt_d = cnt_q - LAST_C;
                        end
                    end
                end
                default: begin
                    st_d  = ST_CHECK;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_CHECK, ST_SELFTEST: check_en = !selftest;
            ST_HOLD:               check_en = 1'b0;
            default:               check_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/tx_parity_checker.sv
module tx_parity_checker
    import tpc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CTL_W      = 2,
    parameter int WINDOW_LEN = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [CTL_W-1:0]  tx_ctl,
    input  logic              tx_par,
    input  logic [1:0]        mode_code,
    input  logic              enc_bypass,
    input  logic              selftest,
    input  logic              sync_req,
    output logic              par_err
);

    cover_e cov;
    logic   odd_data;
    logic   odd_full;
    logic   check_en;
    logic   fail;

    tpc_cover_sel u_cov (
        .mode_code  (mode_code),
        .enc_bypass (enc_bypass),
        .cov        (cov)
    );

    tpc_parity_tree #(
        .DATA_W (DATA_W),
        .CTL_W  (CTL_W)
    ) u_tree (
        .data     (tx_data),
        .ctl      (tx_ctl),
        .par      (tx_par),
        .odd_data (odd_data),
        .odd_full (odd_full)
    );

    tpc_window_ctrl #(
        .WINDOW_LEN (WINDOW_LEN)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .sync_req   (sync_req),
        .selftest   (selftest),
        .check_en   (check_en)
    );

    always_comb begin
        unique case (cov)
            COV_FULL: fail = !odd_full;
            COV_DATA: fail = !odd_data;
            COV_NONE: fail = 1'b0;
            default:  fail = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_err <= 1'b0;
        else        par_err <= char_valid && check_en && fail;
    end

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int DATA_W     = 8,
    parameter int CTL_W      = 2,
    parameter int WINDOW_LEN = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic [CTL_W-1:0]  tx_ctl,
    input logic              tx_par,
    input logic [1:0]        mode_code,
    input logic              enc_bypass,
    input logic              selftest,
    input logic              sync_req,
    input logic              par_err
);

    int   win_q;
    logic full_cov;
    logic data_cov;

    assign full_cov = (mode_code == 2'b11) || (mode_code == 2'b10 && enc_bypass);
    assign data_cov = (mode_code == 2'b10) && !enc_bypass;

    // independent window count kept from the ports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        win_q <= 0;
        else if (selftest)                 win_q <= 0;
        else if (char_valid && sync_req)   win_q <= WINDOW_LEN;
        else if (char_valid && win_q > 0)  win_q <= win_q - 1;
    end

    a_r1_odd_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !selftest && win_q == 0 && full_cov && (^{tx_data, tx_ctl, tx_par}))
        |=> !par_err);

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'b00 || mode_code == 2'b01) |=> !par_err);

    a_r3_full_even_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !selftest && win_q == 0 && full_cov && !(^{tx_data, tx_ctl, tx_par}))
        |=> par_err);

    a_r4_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !selftest && win_q == 0 && data_cov)
        |=> (par_err == $past(~^{tx_data, tx_par})));

    a_r5_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && win_q != 0) |=> !par_err);

    a_r7_selftest_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        selftest |=> !par_err);

    a_r8_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |=> !par_err);

    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !par_err);

endmodule

bind tx_parity_checker tpc_checker #(
    .DATA_W     (DATA_W),
    .CTL_W      (CTL_W),
    .WINDOW_LEN (WINDOW_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .tx_data    (tx_data),
    .tx_ctl     (tx_ctl),
    .tx_par     (tx_par),
    .mode_code  (mode_code),
    .enc_bypass (enc_bypass),
    .selftest   (selftest),
    .sync_req   (sync_req),
    .par_err    (par_err)
);

// File: tb/sim_tx_parity_checker.sv
module sim_tx_parity_checker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic [1:0] tx_ctl = '0;
    logic       tx_par = 1'b0;
    logic [1:0] mode_code = 2'b11;
    logic       enc_bypass = 1'b0;
    logic       selftest = 1'b0;
    logic       sync_req = 1'b0;
    logic       par_err;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    win = 0;
    bit    exp_err = 1'b0;
    bit    done = 1'b0;
    string tag = "R9";

    always #10 clk = ~clk;

    tx_parity_checker u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .tx_data    (tx_data),
        .tx_ctl     (tx_ctl),
        .tx_par     (tx_par),
        .mode_code  (mode_code),
        .enc_bypass (enc_bypass),
        .selftest   (selftest),
        .sync_req   (sync_req),
        .par_err    (par_err)
    );

    // behavioural reference, evaluated at each rising edge
    task automatic model_step();
        bit ones_full;
        bit ones_data;
        bit bad;
        ones_full = ^{tx_data, tx_ctl, tx_par};
        ones_data = ^{tx_data, tx_par};
        if (!rst_n) begin
            exp_err = 1'b0;
            win = 0;
        end else begin
            if (mode_code == 2'b11 || (mode_code == 2'b10 && enc_bypass)) bad = !ones_full;
            else if (mode_code == 2'b10)                                   bad = !ones_data;
            else                                                           bad = 1'b0;
            exp_err = char_valid && !selftest && (win == 0) && bad;
            if (selftest)                  win = 0;
            else if (char_valid && sync_req) win = 15;
            else if (char_valid && win > 0)  win = win - 1;
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (par_err !== exp_err) begin
            n_bad++;
            $display("FAIL %s: par_err=%0b expected %0b at %0t", tag, par_err, exp_err, $time);
        end
    endtask

    task automatic put(bit v, logic [7:0] d, logic [1:0] c, bit p, logic [1:0] m,
                       bit byp, bit st, bit sy, string t);
        char_valid = v; tx_data = d; tx_ctl = c; tx_par = p;
        mode_code = m; enc_bypass = byp; selftest = st; sync_req = sy; tag = t;
        @(posedge clk);
        model_step();
        #5;
        compare();
    endtask

    // full coverage (HIGH, encoder on): par=0 with zero data is even -> flagged
    task automatic bad_hi(string t);  put(1, 8'h00, 2'b00, 1'b0, 2'b11, 0, 0, 0, t); endtask
    task automatic good_hi(string t); put(1, 8'h00, 2'b00, 1'b1, 2'b11, 0, 0, 0, t); endtask
    task automatic idle(string t);    put(0, 8'h00, 2'b00, 1'b0, 2'b11, 0, 0, 0, t); endtask

    initial begin
        // R9: reset state, even with bad characters on the inputs
        #5;
        compare();
        for (int i = 0; i < 3; i++) bad_hi("R9");
        rst_n = 1'b1;
        idle("R9");

        // R1 / R3: HIGH with encoder enabled
        good_hi("R1");
        bad_hi("R1");
        put(1, 8'hA5, 2'b00, 1'b1, 2'b11, 0, 0, 0, "R1");   // 4 ones + 1 -> odd
        put(1, 8'hA5, 2'b01, 1'b1, 2'b11, 0, 0, 0, "R3");   // ctl bit makes it even
        // R3: HIGH with bypass, MID with bypass
        put(1, 8'h01, 2'b10, 1'b1, 2'b11, 1, 0, 0, "R3");
        put(1, 8'h01, 2'b11, 1'b1, 2'b11, 1, 0, 0, "R3");
        put(1, 8'h01, 2'b10, 1'b1, 2'b10, 1, 0, 0, "R3");
        put(1, 8'h01, 2'b11, 1'b1, 2'b10, 1, 0, 0, "R3");
        // R4: MID with encoder enabled ignores ctl
        put(1, 8'h01, 2'b01, 1'b0, 2'b10, 0, 0, 0, "R4");
        put(1, 8'h01, 2'b11, 1'b0, 2'b10, 0, 0, 0, "R4");
        put(1, 8'h03, 2'b01, 1'b0, 2'b10, 0, 0, 0, "R4");
        // R2: LOW and reserved codes never flag
        put(1, 8'h00, 2'b00, 1'b0, 2'b00, 0, 0, 0, "R2");
        put(1, 8'h00, 2'b00, 1'b0, 2'b00, 1, 0, 0, "R2");
        put(1, 8'h00, 2'b00, 1'b0, 2'b01, 0, 0, 0, "R2");
        // R8: no char, no flag; back-to-back bad chars pulse each cycle
        idle("R8");
        bad_hi("R8");
        bad_hi("R8");
        good_hi("R8");
        idle("R8");

        // R5: sync char checked, 15 suppressed, 16th checked; R10 idles don't count
        put(1, 8'h00, 2'b00, 1'b0, 2'b11, 0, 0, 1, "R5");
        for (int i = 0; i < 15; i++) begin
            bad_hi("R5");
            if (i % 4 == 0) idle("R10");
        end
        bad_hi("R5");
        good_hi("R5");

        // R6: restart inside the window
        put(1, 8'h00, 2'b00, 1'b1, 2'b11, 0, 0, 1, "R6");
        for (int i = 0; i < 5; i++) bad_hi("R6");
        put(1, 8'h00, 2'b00, 1'b0, 2'b11, 0, 0, 1, "R6");
        for (int i = 0; i < 15; i++) bad_hi("R6");
        bad_hi("R6");

        // R7: self-test ignores characters and abandons the window
        put(1, 8'h00, 2'b00, 1'b1, 2'b11, 0, 0, 1, "R7");
        bad_hi("R7");
        for (int i = 0; i < 4; i++) put(1, 8'h00, 2'b00, 1'b0, 2'b11, 0, 1, i == 2, "R7");
        bad_hi("R7");
        good_hi("R7");

        // R9: reset mid-window clears it
        put(1, 8'h00, 2'b00, 1'b1, 2'b11, 0, 0, 1, "R9");
        bad_hi("R9");
        rst_n = 1'b0;
        bad_hi("R9");
        rst_n = 1'b1;
        bad_hi("R9");

        // mixed traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            put(($urandom % 4) != 0, 8'($urandom), 2'($urandom), 1'($urandom),
                2'($urandom), 1'($urandom), ($urandom % 20) == 0,
                ($urandom % 25) == 0, "R1");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8: watchdog expired, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule